// File: doc/BRIEF.md
# Mode-Selectable Quadrature Carrier Modulator

This block places a stream of baseband in-phase and quadrature samples onto a digital carrier. A 32-bit phase accumulator advances by a tuning word on every clock. A sine table, indexed by the top phase bits, gives both the sine and the cosine of the carrier. The output is a signed 14-bit sample stream meant for a DAC.

A small mode register selects what the shared datapath produces. The choices are a mixed quadrature signal (the reset default), the bare cosine carrier, or the in-phase input passed straight through. Whatever the mode, the result goes through an 8-bit gain stage that saturates, so an overdriven sample clips and never wraps. Mode, gain and data travel down the pipeline together, so a change applies cleanly from one sample to the next.

Top module: `qmod_core`

## Requirements
- R1: While `rst` is high at a clock edge (synchronous, active high), `out_sample` and `out_valid` become 0, the mode register returns to quadrature (code 0) and the phase accumulator returns to 0.
- R2: At every clock edge out of reset, the 32-bit phase accumulator adds the current `tune_word`, modulo 2^32. A new tuning word applies from the edge at which it is first sampled, and a mode write does not disturb the accumulator.
- R3: The table index k is phase bits [31:24] (256 entries). sin(k) = floor(8191*16*k*(128-k) / (5*128*128 - 4*k*(128-k))) for k < 128, and sin(k) = -sin(k-128) otherwise. cos(k) = sin((k+64) mod 256).
- R4: In mode code 0 (quadrature), the pre-gain value is (I*cos - Q*sin) arithmetically shifted right by 13.
- R5: In mode code 1 (single tone), the pre-gain value is cos(k), and the data inputs are ignored.
- R6: In mode code 2 (pass-through), the pre-gain value is `in_i`.
- R7: The output is (pre-gain * `scale`) arithmetically shifted right by 8, with `scale` taken as unsigned. The result clamps to the range -8192 to 8191.
- R8: A sample taken at clock edge t appears after edge t+2 (three register stages). `out_valid` repeats the `in_valid` of that sample in modes 0 and 2, and is always 1 in mode 1.
- R9: A write (`mode_we` high) of code 3 is ignored. Any other write changes the mode used for samples taken from the next edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Baseband sample valid |
| in_i | input | 14 | In-phase sample, signed |
| in_q | input | 14 | Quadrature sample, signed |
| tune_word | input | 32 | Phase increment per clock |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 2 | Mode code: 0 quadrature, 1 tone, 2 pass-through, 3 reserved |
| scale | input | 8 | Output gain, unsigned, divided by 256 |
| out_sample | output | 14 | Signed DAC sample |
| out_valid | output | 1 | Output sample valid |

## Verification
The properties assume that every input is a known value at each clock edge out of reset. They also assume that mode, gain and data, once sampled, say nothing about later cycles, so each property looks back exactly three edges and only after three clean edges following reset. The stimulus drives all inputs on the falling edge from a deterministic generator. It never leaves a signal undriven, and it pulses reset only at the start, so the look-back window always lies within defined activity.

// File: rtl/qmod_core.sv
module qmod_core #(
  parameter int DW  = 14,
  parameter int PW  = 32,
  parameter int LB  = 8,
  parameter int SCW = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic signed [DW-1:0]  in_i,
  input  logic signed [DW-1:0]  in_q,
  input  logic [PW-1:0]         tune_word,
  input  logic                  mode_we,
  input  logic [1:0]            mode_wdata,
  input  logic [SCW-1:0]        scale,
  output logic signed [DW-1:0]  out_sample,
  output logic                  out_valid
);
  localparam int TSIZE = 1 << LB;
  localparam int HALF  = TSIZE / 2;
  localparam int QTR   = TSIZE / 4;
  localparam int AMP   = (1 << (DW - 1)) - 1;
  localparam int MW    = DW + 2;
  localparam int XW    = 2 * DW + 1;
  localparam int PRW   = MW + SCW + 1;
  localparam logic [1:0] M_QUAD = 2'd0;
  localparam logic [1:0] M_TONE = 2'd1;
  localparam logic [1:0] M_PASS = 2'd2;
  localparam logic [1:0] M_RSVD = 2'd3;
  localparam logic signed [PRW-1:0] OMAX = PRW'(AMP);
  localparam logic signed [PRW-1:0] OMIN = -OMAX - PRW'(1);

  function automatic int half_sine(input int k);
    longint p, num, den;
    p   = longint'(k) * longint'(HALF - k);
    num = longint'(AMP) * 16 * p;
    den = 5 * longint'(HALF) * longint'(HALF) - 4 * p;
    return int'(num / den);
  endfunction

  function automatic int sine_at(input int k);
    return (k < HALF) ? half_sine(k) : -half_sine(k - HALF);
  endfunction

  logic signed [DW-1:0] sin_tab [TSIZE];
  for (genvar g = 0; g < TSIZE; g++) begin : g_tab
    assign sin_tab[g] = DW'(sine_at(g));
  end

  logic [1:0]    mode_q;
  logic [PW-1:0] acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= M_QUAD;
      acc    <= '0;
    end else begin
      acc <= acc + tune_word;
      if (mode_we && mode_wdata != M_RSVD) mode_q <= mode_wdata;
    end
  end

  wire [LB-1:0] s_idx = acc[PW-1 -: LB];
  wire [LB-1:0] c_idx = s_idx + LB'(QTR);

  logic signed [DW-1:0] a_sin, a_cos, a_i, a_q;
  logic                 a_v;
  logic [1:0]           a_mode;
  logic [SCW-1:0]       a_scale;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_sin <= '0; a_cos <= '0; a_i <= '0; a_q <= '0;
      a_v <= 1'b0; a_mode <= M_QUAD; a_scale <= '0;
    end else begin
      a_sin   <= sin_tab[s_idx];
      a_cos   <= sin_tab[c_idx];
      a_i     <= in_i;
      a_q     <= in_q;
      a_v     <= in_valid;
      a_mode  <= mode_q;
      a_scale <= scale;
    end
  end

  logic signed [XW-1:0] a_sum;
  logic signed [MW-1:0] a_shift, mix_next;
  assign a_sum   = XW'(a_i) * XW'(a_cos) - XW'(a_q) * XW'(a_sin);
  assign a_shift = MW'(a_sum >>> (DW - 1));

  always_comb begin
    case (a_mode)
      M_TONE:  mix_next = {{(MW-DW){a_cos[DW-1]}}, a_cos};
      M_PASS:  mix_next = {{(MW-DW){a_i[DW-1]}}, a_i};
      default: mix_next = a_shift;
    endcase
  end

  logic signed [MW-1:0] b_mix;
  logic                 b_v;
  logic [SCW-1:0]       b_scale;

  always_ff @(posedge clk) begin
    if (rst) begin
      b_mix <= '0; b_v <= 1'b0; b_scale <= '0;
    end else begin
      b_mix   <= mix_next;
      b_v     <= (a_mode == M_TONE) ? 1'b1 : a_v;
      b_scale <= a_scale;
    end
  end

  logic signed [PRW-1:0] c_prod, c_sh;
  logic signed [DW-1:0]  c_sat;
  assign c_prod = PRW'(b_mix) * PRW'($signed({1'b0, b_scale}));
  assign c_sh   = c_prod >>> SCW;
  assign c_sat  = (c_sh > OMAX) ? DW'(OMAX) :
                  (c_sh < OMIN) ? DW'(OMIN) : DW'(c_sh);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_sample <= '0;
      out_valid  <= 1'b0;
    end else begin
      out_sample <= c_sat;
      out_valid  <= b_v;
    end
  end
endmodule

// File: rtl/qmod_core_chk.sv
module qmod_core_chk #(
  parameter int DW  = 14,
  parameter int SCW = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic signed [DW-1:0] in_i,
  input logic                 mode_we,
  input logic [1:0]           mode_wdata,
  input logic [SCW-1:0]       scale,
  input logic [1:0]           mode_q,
  input logic signed [DW-1:0] out_sample,
  input logic                 out_valid
);
  logic [1:0] cyc;
  always_ff @(posedge clk) begin
    if (rst) cyc <= 2'd0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  assert_valid_follows_R8: assert property (@(posedge clk) disable iff (rst)
    (cyc == 2'd3 && $past(mode_q, 3) != 2'd1) |-> (out_valid == $past(in_valid, 3)));

  assert_tone_valid_R8: assert property (@(posedge clk) disable iff (rst)
    (cyc == 2'd3 && $past(mode_q, 3) == 2'd1) |-> out_valid);

  assert_zero_gain_R7: assert property (@(posedge clk) disable iff (rst)
    (cyc == 2'd3 && $past(scale, 3) == '0) |-> (out_sample == '0));

  assert_pass_sign_R6: assert property (@(posedge clk) disable iff (rst)
    (cyc == 2'd3 && $past(mode_q, 3) == 2'd2 && !$past(in_i[DW-1], 3)) |-> !out_sample[DW-1]);

  assert_rsvd_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (cyc != 2'd0 && $past(mode_we) && $past(mode_wdata) == 2'd3) |-> $stable(mode_q));
endmodule

bind qmod_core qmod_core_chk #(.DW(DW), .SCW(SCW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i),
  .mode_we(mode_we), .mode_wdata(mode_wdata), .scale(scale),
  .mode_q(mode_q), .out_sample(out_sample), .out_valid(out_valid)
);

// File: tb/qmod_core_bench.sv
module qmod_core_bench;
  localparam time TCLK = 10ns;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               in_valid = 1'b0;
  logic signed [13:0] in_i = '0;
  logic signed [13:0] in_q = '0;
  logic [31:0]        tune_word = '0;
  logic               mode_we = 1'b0;
  logic [1:0]         mode_wdata = '0;
  logic [7:0]         scale = '0;
  logic signed [13:0] out_sample;
  logic               out_valid;

  always #(TCLK/2) clk = ~clk;

  qmod_core u_qmod_core (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .tune_word(tune_word), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .scale(scale), .out_sample(out_sample), .out_valid(out_valid)
  );

  typedef struct { bit v; int d; string tag; } exp_t;
  exp_t sb[$];
  int checks = 0;
  int errors = 0;
  logic [31:0] m_acc = '0;
  int m_mode = 0;

  function automatic int ref_sin(input int k);
    longint p;
    int kk;
    kk = k % 256;
    if (kk >= 128) return -ref_sin(kk - 128);
    p = longint'(kk) * longint'(128 - kk);
    return int'((longint'(8191) * 16 * p) / (longint'(5 * 128 * 128) - 4 * p));
  endfunction

  task automatic monitor();
    exp_t e;
    int got;
    if (sb.size() == 3) begin
      e = sb.pop_front();
      got = out_sample;
      checks++;
      if (out_valid !== e.v || (e.v && got != e.d)) begin
        errors++;
        $display("FAIL %s: valid=%0b data=%0d expected valid=%0b data=%0d",
                 e.tag, out_valid, got, e.v, e.d);
      end
    end
  endtask

  task automatic step(input bit v, input int i, input int q, input logic [31:0] ftw,
                      input bit we, input int wd, input int sc, input string tag);
    exp_t e;
    int idx, s, c, mix, y;
    @(negedge clk);
    monitor();
    in_valid = v; in_i = 14'(i); in_q = 14'(q); tune_word = ftw;
    mode_we = we; mode_wdata = 2'(wd); scale = 8'(sc);
    idx = int'(m_acc[31:24]);
    s = ref_sin(idx);
    c = ref_sin(idx + 64);
    case (m_mode)
      1: mix = c;
      2: mix = i;
      default: mix = (i * c - q * s) >>> 13;
    endcase
    y = (mix * sc) >>> 8;
    e.tag = tag;
    if (y > 8191) begin y = 8191; e.tag = "R7"; end
    if (y < -8192) begin y = -8192; e.tag = "R7"; end
    e.v = (m_mode == 1) ? 1'b1 : v;
    e.d = y;
    sb.push_back(e);
    m_acc = m_acc + ftw;   // R2
    if (we && wd != 3) m_mode = wd;   // R9
  endtask

  function automatic int rnd(input int lo, input int hi);
    return lo + int'($urandom_range(32'(hi - lo)));
  endfunction

  initial begin
    exp_t e0;
    repeat (3) @(negedge clk);
    checks++;
    if (out_sample !== 14'sd0 || out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1: valid=%0b data=%0d expected valid=0 data=0", out_valid, out_sample);
    end
    rst = 1'b0;
    e0.v = 1'b0; e0.d = 0; e0.tag = "R1";
    sb.push_back(e0);

    // R4 quadrature, moderate amplitude, R3 table through phase sweep
    for (int n = 0; n < 40; n++)
      step(1, rnd(-4000, 4000), rnd(-4000, 4000), 32'h0123_4567, 0, 0, 255, "R4");
    for (int n = 0; n < 40; n++)
      step(n % 3 != 0, rnd(-8192, 8191), rnd(-8192, 8191), 32'h0377_1234, 0, 0, 128, "R8");
    // R7 saturation with full-scale inputs
    for (int n = 0; n < 20; n++)
      step(1, (n % 2) ? 8191 : -8192, (n % 2) ? -8192 : 8191, 32'h0200_0000, 0, 0, 255, "R7");
    // switch to tone; R5 data ignored, valid forced high
    step(1, 100, 200, 32'h0800_0000, 1, 1, 255, "R9");
    for (int n = 0; n < 30; n++)
      step(n % 2, rnd(-8192, 8191), rnd(-8192, 8191), (n < 15) ? 32'h0800_0000 : 32'h0155_5555, 0, 0, 200, "R5");
    // R9 reserved code ignored: stays in tone
    step(0, 0, 0, 32'h0400_0000, 1, 3, 255, "R9");
    for (int n = 0; n < 10; n++)
      step(0, 500, 500, 32'h0400_0000, 0, 0, 255, "R9");
    // R6 pass-through, gains including zero
    step(1, 1000, 0, 32'h0400_0000, 1, 2, 255, "R9");
    for (int n = 0; n < 30; n++)
      step(n % 4 != 1, rnd(-8192, 8191), rnd(-8192, 8191), 32'h0400_0000, 0, 0,
           (n % 5 == 0) ? 0 : rnd(1, 255), "R6");
    // R2 zero increment holds phase, large increment wraps
    step(1, 0, 0, 32'h0, 1, 1, 255, "R2");
    for (int n = 0; n < 10; n++) step(1, 0, 0, 32'h0, 0, 0, 255, "R2");
    for (int n = 0; n < 20; n++) step(1, 0, 0, 32'hFF00_0000, 0, 0, 255, "R2");
    // back to quadrature, phase carried over
    step(1, 3000, -3000, 32'h00A0_0000, 1, 0, 255, "R2");
    for (int n = 0; n < 20; n++)
      step(1, rnd(-8192, 8191), rnd(-8192, 8191), 32'h00A0_0000, 0, 0, rnd(0, 255), "R4");
    repeat (3) step(0, 0, 0, 32'h0, 0, 0, 0, "R8");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule